// File: doc/BRIEF.md
# Paged Program-Counter High Byte and Return-Address Sequencer

This block holds the upper eight address bits of a 24-bit program counter for an 8051-class core. It also holds a separate 8-bit page register that software loads over the special-function-register bus. The low counter stays outside the block and is seen only through its current value. When the two addressing-mode bits select paged operation, a long jump or long call copies the page register into the high byte. A carry out of the low counter never reaches the high byte. In the other modes the high byte is left alone, and the page register is an ordinary read/write SFR.

The block also runs the byte sequence for saving and restoring the return address. A push request stores the low byte first and then the middle byte. In paged mode a third byte follows, which is the high byte. A pop request reads the bytes back in the reverse order. A pop then presents the rebuilt low address for one cycle and, in paged mode, reloads the high byte. The extra byte costs exactly one extra cycle in each direction.

Top module: `pc_page_ctl`

## Requirements
- R1: After reset the page register reads 00h, the high byte is 00h, and no push, pop or busy indication is active.
- R2: An SFR write to address 9Ch updates the page register on the next clock edge. Reading address 9Ch returns the page register, and reading any other address returns 00h. Writes to other addresses leave the page register unchanged.
- R3: With mode bits equal to 01b, a long transfer makes the high byte equal the page register value from that cycle after the next edge.
- R4: With mode bits other than 01b, a long transfer leaves the high byte unchanged, and the page register stays readable and writable.
- R5: If an SFR page write and a paged long transfer share a cycle, the high byte takes the old page value and the page register takes the new one.
- R6: The high byte does not change when the low counter input wraps from FFFFh to 0000h, or at any time without a long transfer or a return load.
- R7: A push request in paged mode produces three consecutive push cycles carrying PC[7:0], PC[15:8], PC[23:16]. In other modes it produces two cycles carrying PC[7:0], PC[15:8]. The push strobe then drops.
- R8: A push sequence leaves the page register unchanged.
- R9: A pop request in paged mode produces three pop cycles, with the stack data in each cycle taken as PC[23:16], then PC[15:8], then PC[7:0]. In other modes it produces two pop cycles, taken as PC[15:8] then PC[7:0]. In the cycle after the last pop, the return-valid strobe is high for one cycle with the rebuilt low 16 bits. The high byte takes the popped value only in paged mode.
- R10: Busy is high throughout a sequence. Push or pop requests that arrive while busy are ignored, and the mode is latched when a sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_mode | input | 2 | Addressing-mode bits; 01b selects paged mode |
| sfr_addr | input | 8 | SFR bus address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (page register at 9Ch, else 00h) |
| long_xfer | input | 1 | Long jump or long call executing this cycle |
| pc_lo | input | 16 | Current low 16 bits of the program counter |
| pc_hi | output | 8 | High program-counter byte, drives address bits 23:16 |
| push_start | input | 1 | Request a return-address push sequence |
| pop_start | input | 1 | Request a return-address pop sequence |
| stk_push | output | 1 | Stack write strobe, one byte per cycle |
| stk_wdata | output | 8 | Byte to push |
| stk_pop | output | 1 | Stack read strobe, one byte per cycle |
| stk_rdata | input | 8 | Byte popped, valid in the cycle stk_pop is high |
| busy | output | 1 | A push or pop sequence is in progress |
| ret_valid | output | 1 | One-cycle strobe: rebuilt return address available |
| ret_lo | output | 16 | Rebuilt low 16 bits of the return address |

## Verification
The bench targets a same-cycle page write and long jump. A design that forwarded the new value would place the wrong page in the high byte. A low counter that wraps from FFFFh to 0000h must not bump the high byte, as it would if the block treated that byte as a counter. Push and pop round trips across all mode codes check the byte order and the byte count. A reversed order or a missing third byte would corrupt the rebuilt address, and a non-paged pop that touched the high byte would show up as a changed pc_hi. Requests held high during a sequence check that a sequence is not restarted or extended.

// File: rtl/pcpg_pkg.sv
package pcpg_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PUSH = 2'd1,
      SQ_POP  = 2'd2
   } seq_st_e;

   localparam logic [1:0] MODE_PAGED_DEF = 2'b01;
endpackage

// File: rtl/pcpg_page_reg.sv
module pcpg_page_reg #(
   parameter int          AW        = 8,
   parameter int          DW        = 8,
   parameter logic [AW-1:0] PAGE_ADDR = 8'h9C,
   parameter bit          ZERO_UNMAPPED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] sfr_addr,
   input  logic          sfr_wr,
   input  logic [DW-1:0] sfr_wdata,
   output logic [DW-1:0] page_q,
   output logic [DW-1:0] sfr_rdata
);
   logic hit;
   assign hit = (sfr_addr == PAGE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            page_q <= '0;
      else if (sfr_wr && hit) page_q <= sfr_wdata;
   end

   generate
      if (ZERO_UNMAPPED) begin : g_mask
         assign sfr_rdata = hit ? page_q : '0;
      end else begin : g_open
         assign sfr_rdata = page_q;
      end
   endgenerate

   // R2
   foreign_wr_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && !hit) |=> $stable(page_q));
   // R2
   page_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && hit) |=> (page_q == $past(sfr_wdata)));
endmodule

// File: rtl/pcpg_hi_reg.sv
module pcpg_hi_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          paged,
   input  logic          long_xfer,
   input  logic [DW-1:0] page_in,
   input  logic          ret_hi_load,
   input  logic [DW-1:0] ret_hi,
   output logic [DW-1:0] pc_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pc_hi <= '0;
      else if (ret_hi_load)        pc_hi <= ret_hi;
      else if (long_xfer && paged) pc_hi <= page_in;
   end

   // R3
   paged_jump_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (long_xfer && paged && !ret_hi_load) |=> (pc_hi == $past(page_in)));
   // R4
   flat_jump_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (long_xfer && !paged && !ret_hi_load) |=> $stable(pc_hi));
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!long_xfer && !ret_hi_load) |=> $stable(pc_hi));
endmodule

// File: rtl/pcpg_stack_seq.sv
module pcpg_stack_seq
   import pcpg_pkg::*;
#(
   parameter int LO_W = 16,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            paged,
   input  logic            push_start,
   input  logic            pop_start,
   input  logic [DW-1:0]   pc_hi,
   input  logic [LO_W-1:0] pc_lo,
   output logic            stk_push,
   output logic            stk_pop,
   output logic [DW-1:0]   stk_wdata,
   input  logic [DW-1:0]   stk_rdata,
   output logic            busy,
   output logic            ret_valid,
   output logic [LO_W-1:0] ret_lo,
   output logic [DW-1:0]   ret_hi,
   output logic            ret_hi_load
);
   localparam int LO_BYTES = LO_W / DW;
   localparam int TOT      = LO_BYTES + 1;
   localparam int FW       = DW * TOT;
   localparam int CW       = $clog2(TOT + 1);

   seq_st_e        st_q;
   logic [FW-1:0]  snap_q;
   logic [CW-1:0]  cnt_q, last_q, pop_idx;
   logic           hi_q, ret_q;
   logic [DW-1:0]  snap_b [TOT];

   generate
      for (genvar g = 0; g < TOT; g++) begin : g_slice
         assign snap_b[g] = snap_q[DW*g +: DW];
      end
   endgenerate

   assign pop_idx = last_q - cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         snap_q <= '0;
         cnt_q  <= '0;
         last_q <= '0;
         hi_q   <= 1'b0;
         ret_q  <= 1'b0;
      end else begin
         ret_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (push_start || pop_start) begin
                  cnt_q  <= '0;
                  hi_q   <= paged;
                  last_q <= paged ? CW'(TOT - 1) : CW'(LO_BYTES - 1);
               end
               if (push_start) begin
                  snap_q <= {pc_hi, pc_lo};
                  st_q   <= SQ_PUSH;
               end else if (pop_start) begin
                  snap_q <= '0;
                  st_q   <= SQ_POP;
               end
            end
            SQ_PUSH: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == last_q) st_q <= SQ_IDLE;
            end
            SQ_POP: begin
               for (int b = 0; b < TOT; b++)
                  if (CW'(b) == pop_idx) snap_q[DW*b +: DW] <= stk_rdata;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == last_q) begin
                  st_q  <= SQ_IDLE;
                  ret_q <= 1'b1;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      stk_wdata = '0;
      for (int b = 0; b < TOT; b++)
         if (CW'(b) == cnt_q) stk_wdata = snap_b[b];
   end

   assign stk_push    = (st_q == SQ_PUSH);
   assign stk_pop     = (st_q == SQ_POP);
   assign busy        = (st_q != SQ_IDLE);
   assign ret_valid   = ret_q;
   assign ret_lo      = snap_q[LO_W-1:0];
   assign ret_hi      = snap_b[TOT-1];
   assign ret_hi_load = ret_q && hi_q;

   // R7
   one_stack_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_push, stk_pop, ret_valid}));
   // R9
   ret_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> $past(stk_pop));
   // R9
   ret_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> !ret_valid);
   // R10
   busy_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(hi_q));
endmodule

// File: rtl/pc_page_ctl.sv
module pc_page_ctl
   import pcpg_pkg::*;
#(
   parameter int         LO_W       = 16,
   parameter int         SFR_AW     = 8,
   parameter logic [7:0] PAGE_ADDR  = 8'h9C,
   parameter logic [1:0] PAGED_CODE = MODE_PAGED_DEF,
   parameter bit         ZERO_UNMAPPED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_mode,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              long_xfer,
   input  logic [LO_W-1:0]   pc_lo,
   output logic [7:0]        pc_hi,
   input  logic              push_start,
   input  logic              pop_start,
   output logic              stk_push,
   output logic [7:0]        stk_wdata,
   output logic              stk_pop,
   input  logic [7:0]        stk_rdata,
   output logic              busy,
   output logic              ret_valid,
   output logic [LO_W-1:0]   ret_lo
);
   localparam int DW = 8;

   generate
      if ((LO_W % DW) != 0 || LO_W < DW) begin : g_bad_lo
         $error("LO_W must be a positive multiple of 8");
      end
      if (SFR_AW < 8) begin : g_bad_aw
         $error("SFR_AW must be at least 8");
      end
   endgenerate

   logic          paged;
   logic [DW-1:0] page_q, ret_hi;
   logic          ret_hi_load;

   assign paged = (addr_mode == PAGED_CODE);

   pcpg_page_reg #(
      .AW(SFR_AW), .DW(DW),
      .PAGE_ADDR(SFR_AW'(PAGE_ADDR)), .ZERO_UNMAPPED(ZERO_UNMAPPED)
   ) u_page (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .page_q(page_q), .sfr_rdata(sfr_rdata)
   );

   pcpg_hi_reg #(.DW(DW)) u_hi (
      .clk(clk), .rst_n(rst_n), .paged(paged), .long_xfer(long_xfer),
      .page_in(page_q), .ret_hi_load(ret_hi_load), .ret_hi(ret_hi),
      .pc_hi(pc_hi)
   );

   pcpg_stack_seq #(.LO_W(LO_W), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .paged(paged),
      .push_start(push_start), .pop_start(pop_start),
      .pc_hi(pc_hi), .pc_lo(pc_lo),
      .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
      .stk_rdata(stk_rdata), .busy(busy), .ret_valid(ret_valid),
      .ret_lo(ret_lo), .ret_hi(ret_hi), .ret_hi_load(ret_hi_load)
   );

   // R8
   push_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push && !sfr_wr) |=> $stable(page_q));
   // R10
   busy_covers_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push || stk_pop) |-> busy);
endmodule

// File: tb/tb_pc_page_ctl.sv
module tb_pc_page_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr_mode = 2'b00;
   logic [7:0]  sfr_addr = 8'h00;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        long_xfer = 1'b0;
   logic [15:0] pc_lo = 16'h0000;
   logic [7:0]  pc_hi;
   logic        push_start = 1'b0;
   logic        pop_start = 1'b0;
   logic        stk_push, stk_pop, busy, ret_valid;
   logic [7:0]  stk_wdata;
   logic [7:0]  stk_rdata = 8'h00;
   logic [15:0] ret_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] page_m = 8'h00;
   logic [7:0] hi_m = 8'h00;
   logic [7:0] stk_m [32];
   int sp_m = 0;

   always #4 clk = ~clk;

   pc_page_ctl dut (
      .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .sfr_addr(sfr_addr),
      .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .long_xfer(long_xfer), .pc_lo(pc_lo), .pc_hi(pc_hi),
      .push_start(push_start), .pop_start(pop_start), .stk_push(stk_push),
      .stk_wdata(stk_wdata), .stk_pop(stk_pop), .stk_rdata(stk_rdata),
      .busy(busy), .ret_valid(ret_valid), .ret_lo(ret_lo)
   );

   function automatic bit is_paged(input logic [1:0] m);
      return m == 2'b01;
   endfunction

   function automatic logic [7:0] push_byte(input int i, input logic [15:0] lo,
                                            input logic [7:0] hi);
      return (i == 0) ? lo[7:0] : (i == 1) ? lo[15:8] : hi;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic read_page;
      sfr_addr = 8'h9C;
      #1;
      chk(sfr_rdata == page_m, "R2 readback", sfr_rdata, page_m);
      sfr_addr = 8'h9C ^ 8'(1 + $urandom_range(0, 254));
      #1;
      chk(sfr_rdata == 8'h00, "R2 unmapped read", sfr_rdata, 0);
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
      if (a == 8'h9C) page_m = d;
      read_page();
   endtask

   task automatic long_jump(input logic [1:0] m, input bit wr_too, input logic [7:0] d);
      addr_mode = m; long_xfer = 1'b1;
      if (wr_too) begin sfr_addr = 8'h9C; sfr_wdata = d; sfr_wr = 1'b1; end
      @(negedge clk);
      long_xfer = 1'b0; sfr_wr = 1'b0;
      if (is_paged(m)) hi_m = page_m;
      if (wr_too) page_m = d;
      if (wr_too)
         chk(pc_hi == hi_m, "R5 same-cycle page write", pc_hi, hi_m);
      else if (is_paged(m))
         chk(pc_hi == hi_m, "R3 paged long jump", pc_hi, hi_m);
      else
         chk(pc_hi == hi_m, "R4 flat long jump", pc_hi, hi_m);
      read_page();
   endtask

   task automatic push_seq(input logic [1:0] m, input logic [15:0] lo, input bit hold);
      int n;
      n = is_paged(m) ? 3 : 2;
      addr_mode = m; pc_lo = lo; push_start = 1'b1;
      @(negedge clk);
      push_start = hold;
      addr_mode = 2'(addr_mode + 2'd1);
      for (int i = 0; i < n; i++) begin
         chk(stk_push && busy && stk_wdata == push_byte(i, lo, hi_m), "R7 push byte",
             {stk_push, stk_wdata}, {1'b1, push_byte(i, lo, hi_m)});
         stk_m[sp_m] = stk_wdata; sp_m++;
         if (i == n - 1) push_start = 1'b0;
         @(negedge clk);
      end
      chk(!stk_push && !busy, "R10 push length", {stk_push, busy}, 0);
      sfr_addr = 8'h9C;
      #1;
      chk(sfr_rdata == page_m, "R8 page after push", sfr_rdata, page_m);
   endtask

   task automatic pop_seq(input logic [1:0] m, input bit hold);
      int n;
      logic [23:0] got;
      n = is_paged(m) ? 3 : 2;
      got = 24'h0;
      addr_mode = m; pop_start = 1'b1;
      @(negedge clk);
      pop_start = hold;
      addr_mode = 2'(addr_mode + 2'd1);
      for (int i = 0; i < n; i++) begin
         chk(stk_pop && busy, "R9 pop strobe", {stk_pop, busy}, 2'b11);
         sp_m--;
         stk_rdata = stk_m[sp_m];
         got[8*(n-1-i) +: 8] = stk_rdata;
         if (i == n - 1) pop_start = 1'b0;
         @(negedge clk);
      end
      stk_rdata = 8'h00;
      chk(ret_valid && !busy && ret_lo == got[15:0], "R9 return address",
          {ret_valid, ret_lo}, {1'b1, got[15:0]});
      if (is_paged(m)) hi_m = got[23:16];
      @(negedge clk);
      chk(pc_hi == hi_m && !ret_valid && !stk_pop, "R9 high byte after return",
          {ret_valid, pc_hi}, {1'b0, hi_m});
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] m;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      sfr_addr = 8'h9C;
      #1;
      chk(sfr_rdata == 8'h00 && pc_hi == 8'h00, "R1 reset values", {sfr_rdata, pc_hi}, 0);
      chk(!busy && !stk_push && !stk_pop && !ret_valid, "R1 idle",
          {busy, stk_push, stk_pop, ret_valid}, 0);

      // directed corner cases
      sfr_write(8'h9C, 8'h5A);
      sfr_write(8'h9B, 8'hFF);
      long_jump(2'b00, 1'b0, 8'h00);
      long_jump(2'b01, 1'b1, 8'hC3);
      long_jump(2'b01, 1'b0, 8'h00);
      pc_lo = 16'hFFFF;
      @(negedge clk);
      pc_lo = 16'h0000;
      repeat (2) @(negedge clk);
      chk(pc_hi == hi_m, "R6 low counter wrap", pc_hi, hi_m);
      push_seq(2'b01, 16'hBEEF, 1'b1);
      pop_seq(2'b01, 1'b1);
      push_seq(2'b10, 16'h1234, 1'b0);
      pop_seq(2'b10, 1'b0);

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         m = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'($urandom_range(0, 3));
         case ($urandom_range(0, 4))
            0: sfr_write(($urandom_range(0, 1) == 0) ? 8'h9C : 8'($urandom_range(0, 255)),
                         8'($urandom_range(0, 255)));
            1: long_jump(m, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
            2: begin
               push_seq(m, 16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));
               pop_seq(m, 1'($urandom_range(0, 1)));
            end
            3: begin
               pc_lo = 16'($urandom_range(0, 65535));
               repeat (2) @(negedge clk);
               chk(pc_hi == hi_m, "R6 hold without jump", pc_hi, hi_m);
            end
            default: begin
               pc_lo = 16'hFFFF;
               @(negedge clk);
               pc_lo = 16'h0000;
               @(negedge clk);
               chk(pc_hi == hi_m, "R6 wrap", pc_hi, hi_m);
            end
         endcase
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule